// File: doc/BRIEF.md
# Sharer Vector and Ack Accounting Unit

This unit holds the coherence bookkeeping for one line of a shared, inclusive cache: a bit vector marking which private caches hold a copy, and the index of the cache that holds it exclusively. Commands arriving from the line's controller can set or drop a single sharer bit, empty the vector, or hand the line to one exclusive owner. The unit keeps the sharer count in a register next to the vector, so the count is ready in the same cycle as the vector.

From the stored vector and a requestor index, the unit forms two invalidation masks. One is for forwarded invalidations and leaves out the requestor. The other is for replacement invalidations and covers every sharer. It also forms the signed acknowledgement-count field for the selected kind of response. A separate signed pending counter follows the invalidations sent when a line is evicted. It is loaded from the sharer count, each incoming acknowledgement subtracts its own count from it, and a flag rises when nothing is left outstanding.

Top module: `sharer_ack_unit`

## Requirements
- R1: After a synchronous reset, the vector is empty, the owner is 0, the count is 0, the pending counter is 0 and `all_acks` is 1.
- R2: `add_en` sets bit `add_id` and `rem_en` clears bit `rem_id`, both at the next edge. When both are asserted with different indices, both take effect. Asserting both with the same index is not allowed.
- R3: `clr_en` empties the vector at the next edge and overrides set-exclusive, add and remove. The owner keeps its value.
- R4: `excl_en` without `clr_en` leaves bit `excl_id` as the only sharer and records `excl_id` as the owner. It overrides add and remove.
- R5: `sharer_cnt` always equals the number of set bits in `sharers`.
- R6: `fwd_mask` is `sharers` with the bit of `req_id` cleared. `repl_mask` equals `sharers`.
- R7: When `resp_kind` is 2'b01 (exclusive data), `ack_field` is minus the sharer count, plus one if `req_id` is a sharer. The value is two's complement.
- R8: When `resp_kind` is 2'b10 (upgrade), `ack_field` is minus the sharer count plus one.
- R9: When `resp_kind` is 2'b00 (shared data) or 2'b11, `ack_field` is 0.
- R10: `load_en` loads the pending counter with the sharer count held before the edge. It takes priority over `ack_en`.
- R11: `ack_en` without `load_en` subtracts the signed `ack_val` from the pending counter.
- R12: `all_acks` is 1 exactly when the pending counter is 0. It is registered together with the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_en | input | 1 | Empty the sharer vector |
| excl_en | input | 1 | Make `excl_id` the sole sharer and owner |
| excl_id | input | ID_W | New exclusive owner |
| add_en | input | 1 | Add a sharer |
| add_id | input | ID_W | Sharer to add |
| rem_en | input | 1 | Remove a sharer |
| rem_id | input | ID_W | Sharer to remove |
| req_id | input | ID_W | Requestor for the mask and ack field |
| resp_kind | input | 2 | 00 shared, 01 exclusive, 10 upgrade, 11 as shared |
| load_en | input | 1 | Load pending counter from the sharer count |
| ack_en | input | 1 | An acknowledgement arrived |
| ack_val | input | AW | Signed ack count carried by it |
| sharers | output | N | Sharer vector |
| owner | output | ID_W | Exclusive owner index |
| sharer_cnt | output | ID_W+1 | Population count of the vector |
| fwd_mask | output | N | Forwarded-invalidation targets |
| repl_mask | output | N | Replacement-invalidation targets |
| ack_field | output | AW | Signed ack count for the response |
| pend_cnt | output | AW | Signed pending-ack counter |
| all_acks | output | 1 | Pending counter is zero |

## Verification
A corrupted vector bit does not stay hidden. It shows up at `sharers` and both masks in the cycle after the faulty edge, and it also shows up as a count that disagrees with the vector. A stale or wrongly computed count affects `ack_field` on the same cycle, since that field is combinational from the count. It also affects the pending counter one edge after the next load. A wrong subtraction or a wrong zero flag appears at `pend_cnt` or `all_acks` one edge after the offending acknowledgement, and it stays wrong until the next load. This lets a mismatch be traced back to the cycle that caused it.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    RK_SHARED = 2'b00,
    RK_EXCL   = 2'b01,
    RK_UPGR   = 2'b10,
    RK_RSVD   = 2'b11
  } resp_kind_e;
endpackage

// File: rtl/sat_vector.sv
module sat_vector #(
  parameter int N    = 8,
  parameter int ID_W = $clog2(N),
  parameter int CW   = ID_W + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_en,
  input  logic            excl_en,
  input  logic [ID_W-1:0] excl_id,
  input  logic            add_en,
  input  logic [ID_W-1:0] add_id,
  input  logic            rem_en,
  input  logic [ID_W-1:0] rem_id,
  output logic [N-1:0]    sh_q,
  output logic [ID_W-1:0] own_q,
  output logic [CW-1:0]   cnt_q
);
  logic [N-1:0]    sh_n;
  logic [ID_W-1:0] own_n;
  logic [CW-1:0]   cnt_n;

  // priority: clear > set-exclusive > add/remove
  always_comb begin
    sh_n  = sh_q;
    own_n = own_q;
    if (clr_en) begin
      sh_n = '0;
    end else if (excl_en) begin
      sh_n          = '0;
      sh_n[excl_id] = 1'b1;
      own_n         = excl_id;
    end else begin
      if (rem_en) sh_n[rem_id] = 1'b0;
      if (add_en) sh_n[add_id] = 1'b1;
    end
  end

  always_comb begin
    cnt_n = '0;
    for (int i = 0; i < N; i++) cnt_n = cnt_n + CW'(sh_n[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      own_q <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_n;
      own_q <= own_n;
      cnt_q <= cnt_n;
    end
  end

  assert_no_same_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (add_en && rem_en && !clr_en && !excl_en) |-> (add_id != rem_id));

  assert_cnt_matches_R5: assert property (@(posedge clk) disable iff (rst)
    32'(cnt_q) == $countones(sh_q));

  assert_clear_empties_R3: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> (sh_q == '0));

  assert_excl_single_R4: assert property (@(posedge clk) disable iff (rst)
    (excl_en && !clr_en) |=> (cnt_q == CW'(1) && sh_q[own_q] && own_q == $past(excl_id)));
endmodule

// File: rtl/sat_ackcalc.sv
module sat_ackcalc
  import sat_pkg::*;
#(
  parameter int N    = 8,
  parameter int ID_W = $clog2(N),
  parameter int CW   = ID_W + 1,
  parameter int AW   = ID_W + 2
) (
  input  logic [N-1:0]    sh,
  input  logic [CW-1:0]   cnt,
  input  logic [ID_W-1:0] req_id,
  input  resp_kind_e      kind,
  output logic [N-1:0]    fwd_mask,
  output logic [N-1:0]    repl_mask,
  output logic [AW-1:0]   ack_field
);
  logic          member;
  logic [N-1:0]  req_oh;
  logic [AW-1:0] neg_cnt;

  always_comb begin
    req_oh         = '0;
    req_oh[req_id] = 1'b1;
    member         = sh[req_id];
    fwd_mask       = sh & ~req_oh;
    repl_mask      = sh;
    neg_cnt        = AW'(0) - {1'b0, cnt};
    unique case (kind)
      RK_EXCL: ack_field = neg_cnt + AW'(member);
      RK_UPGR: ack_field = neg_cnt + AW'(1);
      default: ack_field = '0;
    endcase
  end
endmodule

// File: rtl/sat_pending.sv
module sat_pending #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  input  logic          ack_en,
  input  logic [AW-1:0] ack_val,
  output logic [AW-1:0] pend_q,
  output logic          zero_q
);
  logic [AW-1:0] pend_n;

  always_comb begin
    pend_n = pend_q;
    if (load_en)     pend_n = load_val;
    else if (ack_en) pend_n = pend_q - ack_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      zero_q <= 1'b1;
    end else begin
      pend_q <= pend_n;
      zero_q <= (pend_n == '0);
    end
  end

  assert_load_value_R10: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (pend_q == $past(load_val)));

  assert_ack_subtract_R11: assert property (@(posedge clk) disable iff (rst)
    (ack_en && !load_en) |=> (pend_q == $past(pend_q) - $past(ack_val)));

  assert_zero_flag_R12: assert property (@(posedge clk) disable iff (rst)
    zero_q == (pend_q == '0));
endmodule

// File: rtl/sharer_ack_unit.sv
module sharer_ack_unit
  import sat_pkg::*;
#(
  parameter int N    = 8,
  parameter int ID_W = $clog2(N),
  parameter int CW   = ID_W + 1,
  parameter int AW   = ID_W + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_en,
  input  logic            excl_en,
  input  logic [ID_W-1:0] excl_id,
  input  logic            add_en,
  input  logic [ID_W-1:0] add_id,
  input  logic            rem_en,
  input  logic [ID_W-1:0] rem_id,
  input  logic [ID_W-1:0] req_id,
  input  logic [1:0]      resp_kind,
  input  logic            load_en,
  input  logic            ack_en,
  input  logic [AW-1:0]   ack_val,
  output logic [N-1:0]    sharers,
  output logic [ID_W-1:0] owner,
  output logic [CW-1:0]   sharer_cnt,
  output logic [N-1:0]    fwd_mask,
  output logic [N-1:0]    repl_mask,
  output logic [AW-1:0]   ack_field,
  output logic [AW-1:0]   pend_cnt,
  output logic            all_acks
);
  resp_kind_e kind;
  assign kind = resp_kind_e'(resp_kind);

  sat_vector #(.N(N), .ID_W(ID_W), .CW(CW)) u_vec (
    .clk(clk), .rst(rst),
    .clr_en(clr_en), .excl_en(excl_en), .excl_id(excl_id),
    .add_en(add_en), .add_id(add_id), .rem_en(rem_en), .rem_id(rem_id),
    .sh_q(sharers), .own_q(owner), .cnt_q(sharer_cnt)
  );

  sat_ackcalc #(.N(N), .ID_W(ID_W), .CW(CW), .AW(AW)) u_ack (
    .sh(sharers), .cnt(sharer_cnt), .req_id(req_id), .kind(kind),
    .fwd_mask(fwd_mask), .repl_mask(repl_mask), .ack_field(ack_field)
  );

  sat_pending #(.AW(AW)) u_pend (
    .clk(clk), .rst(rst),
    .load_en(load_en), .load_val({1'b0, sharer_cnt}),
    .ack_en(ack_en), .ack_val(ack_val),
    .pend_q(pend_cnt), .zero_q(all_acks)
  );

  assert_fwd_excludes_req_R6: assert property (@(posedge clk) disable iff (rst)
    ($countones(fwd_mask) + 32'(sharers[req_id])) == 32'(sharer_cnt));
endmodule

// File: tb/sim_sharer_ack_unit.sv
module sim_sharer_ack_unit;
  localparam int N    = 8;
  localparam int ID_W = 3;
  localparam int CW   = 4;
  localparam int AW   = 5;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_en = 0, excl_en = 0, add_en = 0, rem_en = 0, load_en = 0, ack_en = 0;
  logic [ID_W-1:0] excl_id = 0, add_id = 0, rem_id = 0, req_id = 0;
  logic [1:0]      resp_kind = 0;
  logic [AW-1:0]   ack_val = 0;
  logic [N-1:0]    sharers, fwd_mask, repl_mask;
  logic [ID_W-1:0] owner;
  logic [CW-1:0]   sharer_cnt;
  logic [AW-1:0]   ack_field, pend_cnt;
  logic            all_acks;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [N-1:0]         m_sh  = '0;
  int                   m_own = 0;
  logic signed [AW-1:0] m_pend = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sharer_ack_unit #(.N(N), .ID_W(ID_W), .CW(CW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .clr_en(clr_en), .excl_en(excl_en), .excl_id(excl_id),
    .add_en(add_en), .add_id(add_id), .rem_en(rem_en), .rem_id(rem_id),
    .req_id(req_id), .resp_kind(resp_kind), .load_en(load_en), .ack_en(ack_en),
    .ack_val(ack_val), .sharers(sharers), .owner(owner), .sharer_cnt(sharer_cnt),
    .fwd_mask(fwd_mask), .repl_mask(repl_mask), .ack_field(ack_field),
    .pend_cnt(pend_cnt), .all_acks(all_acks)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_ack(int rk, int rq);
    int c = $countones(m_sh);
    if (rk == 1) return -c + int'(m_sh[rq]);
    if (rk == 2) return -c + 1;
    return 0;
  endfunction

  task automatic verify(string vtag, int rq, int rk);
    logic [N-1:0] f = m_sh;
    f[rq] = 1'b0;
    chk(vtag, int'(sharers), int'(m_sh));
    chk("R4 owner", int'(owner), m_own);
    chk("R5 count", int'(sharer_cnt), $countones(m_sh));
    chk("R6 fwd mask", int'(fwd_mask), int'(f));
    chk("R6 repl mask", int'(repl_mask), int'(m_sh));
    chk(rk == 1 ? "R7 ack excl" : (rk == 2 ? "R8 ack upgrade" : "R9 ack shared"),
        int'($signed(ack_field)), exp_ack(rk, rq));
    chk("R11 pending", int'($signed(pend_cnt)), int'(m_pend));
    chk("R12 all acks", int'(all_acks), int'(m_pend == 0));
  endtask

  task automatic step(string vtag, bit c, bit x, int xi, bit a, int ai, bit r, int ri,
                      int rq, int rk, bit ld, bit ak, int av);
    int oldc = $countones(m_sh);
    clr_en = c; excl_en = x; excl_id = ID_W'(xi);
    add_en = a; add_id = ID_W'(ai); rem_en = r; rem_id = ID_W'(ri);
    load_en = ld; ack_en = ak; ack_val = AW'(av);
    if (c) m_sh = '0;
    else if (x) begin m_sh = '0; m_sh[xi] = 1'b1; m_own = xi; end
    else begin
      if (r) m_sh[ri] = 1'b0;
      if (a) m_sh[ai] = 1'b1;
    end
    if (ld) m_pend = AW'(oldc);
    else if (ak) m_pend = m_pend - AW'(av);
    @(posedge clk);
    #1;
    req_id = ID_W'(rq); resp_kind = 2'(rk);
    #1;
    verify(vtag, rq, rk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 sharers", int'(sharers), 0);
    chk("R1 owner", int'(owner), 0);
    chk("R1 count", int'(sharer_cnt), 0);
    chk("R1 pending", int'(pend_cnt), 0);
    chk("R1 all acks", int'(all_acks), 1);

    // R4 set-exclusive beats add
    step("R4 excl over add", 0, 1, 5, 1, 2, 0, 0, 5, 1, 0, 0, 0);
    // R2 add two
    step("R2 add", 0, 0, 0, 1, 2, 0, 0, 0, 0, 0, 0, 0);
    step("R2 add", 0, 0, 0, 1, 3, 0, 0, 3, 2, 0, 0, 0);
    // R7 requestor member and non-member
    step("R7 member", 0, 0, 0, 0, 0, 0, 0, 3, 1, 0, 0, 0);
    step("R7 non-member", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    step("R9 reserved", 0, 0, 0, 0, 0, 0, 0, 2, 3, 0, 0, 0);
    // R10 load 3, then R11 acks, R12 flag
    step("R10 load", 0, 0, 0, 0, 0, 0, 0, 2, 0, 1, 0, 0);
    step("R11 ack", 0, 0, 0, 0, 0, 0, 0, 2, 0, 0, 1, 1);
    step("R11 ack2", 0, 0, 0, 0, 0, 0, 0, 2, 0, 0, 1, 2);
    chk("R12 drained", int'(all_acks), 1);
    // R10 load wins over ack
    step("R10 load over ack", 0, 0, 0, 0, 0, 0, 0, 2, 0, 1, 1, 1);
    // R2 add and remove of different bits together
    step("R2 add+rem", 0, 0, 0, 1, 7, 1, 2, 7, 2, 0, 0, 0);
    // R3 clear beats everything, owner kept
    step("R3 clear", 1, 1, 1, 1, 4, 0, 0, 4, 1, 0, 1, 3);
    chk("R3 empty", int'(sharers), 0);
    chk("R3 owner kept", int'(owner), 5);
    step("R11 negative", 0, 0, 0, 0, 0, 0, 0, 0, 2, 0, 1, 1);

    for (int k = 0; k < 2000; k++) begin
      bit c = ($urandom % 20) == 0;
      bit x = ($urandom % 12) == 0;
      bit a = $urandom % 2;
      bit r = $urandom % 2;
      int ai = $urandom % N;
      int ri = $urandom % N;
      bit ld = ($urandom % 10) == 0;
      bit ak = (m_pend > 0) && ($urandom % 2);
      int av = (m_pend >= 2 && ($urandom % 3) == 0) ? 2 : 1;
      if (a && r && ai == ri) r = 0;
      step("R2 random", c, x, $urandom % N, a, ai, r, ri,
           $urandom % N, $urandom % 4, ld, ak, av);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule